// File: doc/BRIEF.md
# Commit-Time Write Buffer With Arbitration

This block is the per-core side of an optimistic transactional memory scheme. While a transaction runs, its stores are parked in a small write buffer, which merges repeated stores to the same word. Loads look up the buffer for forwarding and also mark the L1 line they touch in a read-set bit vector. Nothing leaves the core until commit. To commit, the core raises a request to a shared commit bus. Once the grant arrives, it drives the address and data of every buffered word onto its broadcast output, one word per cycle and in first-store order. It then pulses a done flag and clears its state.

Other cores' commit broadcasts come in on the snoop input as line addresses. A snooped line whose read bit is set means this transaction read stale data, so the block aborts. An abort throws away the buffer and the read set in one cycle. A transaction that runs out of buffer space cannot simply spill. It stalls the store, waits for the commit bus, drains what it holds and keeps the bus. From then on it sends every further store straight out as it happens and ignores snoops until the core ends the transaction. A separate round-robin arbiter module hands out the bus among four such requesters.

Top module: `txn_commit_unit`

## Requirements
- R1: Accepted stores never appear on the broadcast output before the core asks to commit. A word held in the buffer is returned on the forwarding outputs with its newest data when its address is presented on ld_addr.
- R2: A store to an address already in the buffer overwrites that entry and takes no new one, even when the buffer is full. A commit broadcasts each distinct address exactly once, in the order each address was first stored.
- R3: A load marks read bit h(line), where line = ld_addr >> 2 and h XORs the 6-bit slices of line together. In the running, waiting-for-commit and waiting-for-overflow phases, a snoop whose line maps to a set bit makes txn_abort high for exactly one cycle, on the cycle after the snoop. It also drops any pending bus request.
- R4: A snoop whose line maps to a clear read bit causes no abort.
- R5: commit_start with a non-empty buffer raises cbus_req on the next cycle. Broadcasts start on the cycle after cbus_gnt is seen, run one word per cycle, and happen only while the grant is held. In the cycle after the last word, commit_done pulses and cbus_req is low.
- R6: commit_start with an empty buffer pulses commit_done on the next cycle and never raises cbus_req.
- R7: After a commit or an abort, the whole buffer and every read bit are clear on the very next cycle. Forwarding then misses, and earlier-read lines no longer cause aborts.
- R8: A store to a new address while all 16 entries are in use sees st_ready low and raises cbus_req. After the grant, the 16 entries are broadcast in order. The block then becomes irrevocable: st_ready is high and each store appears on the broadcast output in the same cycle it is presented.
- R9: While irrevocable, snoops never cause an abort and the bus stays requested. commit_start ends the transaction with a commit_done pulse and drops cbus_req on the next cycle.
- R10: The arbiter grants at most one requester at a time and keeps a grant for as long as the holder keeps requesting.
- R11: A grant appears one cycle after the request. When the holder releases the bus, the next grant goes to the first requester found by searching upward and wrapping around, starting just past the previous holder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Transactional load, marks the read set |
| ld_addr | input | 16 | Word address for load lookup |
| ld_fwd_hit | output | 1 | Buffer holds ld_addr |
| ld_fwd_data | output | 32 | Buffered data for ld_addr |
| st_valid | input | 1 | Transactional store request |
| st_addr | input | 16 | Store word address |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Store accepted this cycle |
| commit_start | input | 1 | Core asks to end the transaction |
| commit_done | output | 1 | One-cycle pulse, commit finished |
| txn_abort | output | 1 | One-cycle pulse, transaction aborted |
| irrevocable | output | 1 | Overflowed transaction holds the bus |
| cbus_req | output | 1 | Commit bus request |
| cbus_gnt | input | 1 | Commit bus grant |
| bcast_valid | output | 1 | Broadcast word valid |
| bcast_addr | output | 16 | Broadcast word address |
| bcast_data | output | 32 | Broadcast word data |
| snoop_valid | input | 1 | Remote commit line seen |
| snoop_line | input | 14 | Remote committed line address |

## Verification
The bench stores to the same word twice before committing, and stores to a resident word while the buffer is full. A buffer that appended instead of merging would broadcast duplicates or stall too early. Snoops are aimed at a read line, at a neighbouring unread line, at a line read by an already aborted or committed transaction, and at an irrevocable transaction. A read set that kept stale bits, or that failed to protect the irrevocable transaction, would abort wrongly in one of those cases. The overflow run checks that the drain and the following write-through each appear in the correct cycle. A run of arbiter request patterns checks that grants are held by the holder and that the search wraps from index 3 back to index 0.

// File: rtl/txn_pkg.sv
package txn_pkg;
  typedef enum logic [2:0] {
    S_ACTIVE,
    S_REQ,
    S_COMMIT,
    S_OVF_WAIT,
    S_OVF_DRAIN,
    S_IRREV
  } txn_state_e;
endpackage

// File: rtl/txn_write_buffer.sv
module txn_write_buffer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              wr_hit,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              full
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [CNT_W-1:0]  count_q, count_d;
  logic [DEPTH-1:0]  live, lk_match, wr_match;
  logic [PTR_W-1:0]  wr_hit_idx, wr_idx;
  logic              wr_append, wr_merge;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      assign live[g]     = CNT_W'(g) < count_q;
      assign lk_match[g] = live[g] && (addr_q[g] == lk_addr);
      assign wr_match[g] = live[g] && (addr_q[g] == wr_addr);
    end
  endgenerate

  always_comb begin
    lk_data    = '0;
    wr_hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lk_match[i]) lk_data = data_q[i];
      if (wr_match[i]) wr_hit_idx = PTR_W'(i);
    end
  end

  assign lk_hit    = |lk_match;
  assign wr_hit    = |wr_match;
  assign full      = count_q == CNT_W'(DEPTH);
  assign wr_merge  = wr_en && !clear && wr_hit;
  assign wr_append = wr_en && !clear && !wr_hit && !full;
  assign wr_idx    = wr_hit ? wr_hit_idx : count_q[PTR_W-1:0];
  assign rd_addr   = addr_q[rd_idx];
  assign rd_data   = data_q[rd_idx];
  assign count     = count_q;

  always_comb begin
    count_d = count_q;
    if (clear)          count_d = '0;
    else if (wr_append) count_d = count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  always_ff @(posedge clk) begin
    if (wr_merge || wr_append) data_q[wr_idx] <= wr_data;
    if (wr_append)             addr_q[wr_idx] <= wr_addr;
  end

  // R8: the controller must never offer a new address to a full buffer
  assert_no_append_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit && !clear) |-> !full);
  // R7: a clear leaves no live entry behind
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));
endmodule

// File: rtl/txn_read_set.sv
module txn_read_set #(
  parameter int LA_W  = 14,
  parameter int LINES = 64,
  localparam int IDX_W  = $clog2(LINES),
  localparam int NCHUNK = (LA_W + IDX_W - 1) / IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            set_en,
  input  logic [LA_W-1:0] set_line,
  input  logic [LA_W-1:0] chk_line,
  output logic            chk_hit
);
  logic [LINES-1:0] bits_q, bits_d;
  logic [IDX_W-1:0] set_idx, chk_idx;

  function automatic logic [IDX_W-1:0] fold(input logic [LA_W-1:0] line);
    logic [NCHUNK*IDX_W-1:0] pad;
    logic [IDX_W-1:0]        acc;
    pad = (NCHUNK*IDX_W)'(line);
    acc = '0;
    for (int c = 0; c < NCHUNK; c++) acc = acc ^ pad[c*IDX_W +: IDX_W];
    return acc;
  endfunction

  assign set_idx = fold(set_line);
  assign chk_idx = fold(chk_line);
  assign chk_hit = bits_q[chk_idx];

  always_comb begin
    bits_d = bits_q;
    if (clear)       bits_d = '0;
    else if (set_en) bits_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  // R7: every read bit drops together
  assert_clear_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (bits_q == '0));
endmodule

// File: rtl/txn_commit_ctrl.sv
module txn_commit_ctrl
  import txn_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  logic             wb_hit,
  input  logic             wb_full,
  input  logic [CNT_W-1:0] wb_count,
  input  logic             commit_start,
  input  logic             cbus_gnt,
  input  logic             snoop_valid,
  input  logic             snoop_hit,
  output txn_state_e       state,
  output logic             st_ready,
  output logic             wb_wr_en,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             clear_all,
  output logic             cbus_req,
  output logic             txn_abort,
  output logic             commit_done
);
  txn_state_e       state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             abort_q, abort_d, done_q, done_d;
  logic             revocable, abort_now, spill, last_word;

  assign revocable = (state_q == S_ACTIVE) || (state_q == S_REQ) || (state_q == S_OVF_WAIT);
  assign abort_now = revocable && snoop_valid && snoop_hit;
  assign spill     = st_valid && wb_full && !wb_hit;
  assign last_word = (CNT_W'(ptr_q) + CNT_W'(1)) == wb_count;
  assign st_ready  = ((state_q == S_ACTIVE) && !(wb_full && !wb_hit)) || (state_q == S_IRREV);
  assign wb_wr_en  = st_valid && st_ready && (state_q == S_ACTIVE);
  assign cbus_req  = (state_q != S_ACTIVE);

  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    abort_d   = 1'b0;
    done_d    = 1'b0;
    clear_all = 1'b0;
    case (state_q)
      S_ACTIVE: begin
        if (abort_now) begin
          clear_all = 1'b1;
          abort_d   = 1'b1;
        end else if (spill) begin
          state_d = S_OVF_WAIT;
        end else if (commit_start) begin
          if (wb_count == '0 && !wb_wr_en) begin
            clear_all = 1'b1;
            done_d    = 1'b1;
          end else begin
            state_d = S_REQ;
          end
        end
      end
      S_REQ, S_OVF_WAIT: begin
        if (abort_now) begin
          state_d   = S_ACTIVE;
          clear_all = 1'b1;
          abort_d   = 1'b1;
        end else if (cbus_gnt) begin
          state_d = (state_q == S_REQ) ? S_COMMIT : S_OVF_DRAIN;
          ptr_d   = '0;
        end
      end
      S_COMMIT, S_OVF_DRAIN: begin
        if (last_word) begin
          state_d   = (state_q == S_COMMIT) ? S_ACTIVE : S_IRREV;
          clear_all = 1'b1;
          done_d    = (state_q == S_COMMIT);
        end else begin
          ptr_d = ptr_q + PTR_W'(1);
        end
      end
      S_IRREV: begin
        if (commit_start) begin
          state_d   = S_ACTIVE;
          clear_all = 1'b1;
          done_d    = 1'b1;
        end
      end
      default: state_d = S_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_ACTIVE;
      ptr_q   <= '0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      abort_q <= abort_d;
      done_q  <= done_d;
    end
  end

  assign state       = state_q;
  assign rd_ptr      = ptr_q;
  assign txn_abort   = abort_q;
  assign commit_done = done_q;

  // R9: an irrevocable transaction is never aborted
  assert_irrev_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IRREV) |=> !txn_abort);
  // R3: abort and commit completion never coincide
  assert_abort_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(txn_abort && commit_done));
endmodule

// File: rtl/commit_bus_arbiter.sv
module commit_bus_arbiter #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N-1:0]  gnt_q, gnt_d;
  logic [IW-1:0] last_q, last_d;
  logic          found;

  always_comb begin
    gnt_d  = '0;
    last_d = last_q;
    found  = 1'b0;
    if ((gnt_q & req) != '0) begin
      gnt_d = gnt_q;
    end else begin
      for (int k = 1; k <= N; k++) begin
        int j;
        j = (int'(last_q) + k) % N;
        if (!found && req[j]) begin
          gnt_d[j] = 1'b1;
          last_d   = IW'(j);
          found    = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      last_q <= IW'(N - 1);
    end else begin
      gnt_q  <= gnt_d;
      last_q <= last_d;
    end
  end

  assign gnt = gnt_q;

  // R10: one holder at most
  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));
  // R10: a requesting holder keeps the bus
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_q & req) != '0) |=> (gnt_q == $past(gnt_q)));
  // R11: a grant only follows a request
  assert_grant_from_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != '0) |-> ((gnt_q & $past(req)) != '0));
endmodule

// File: rtl/txn_commit_unit.sv
module txn_commit_unit
  import txn_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int WB_DEPTH   = 16,
  parameter int L1_LINES   = 64,
  parameter int LINE_WORDS = 4,
  localparam int LINE_W = $clog2(LINE_WORDS),
  localparam int LA_W   = ADDR_W - LINE_W,
  localparam int CNT_W  = $clog2(WB_DEPTH + 1),
  localparam int PTR_W  = $clog2(WB_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_fwd_hit,
  output logic [DATA_W-1:0] ld_fwd_data,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_ready,
  input  logic              commit_start,
  output logic              commit_done,
  output logic              txn_abort,
  output logic              irrevocable,
  output logic              cbus_req,
  input  logic              cbus_gnt,
  output logic              bcast_valid,
  output logic [ADDR_W-1:0] bcast_addr,
  output logic [DATA_W-1:0] bcast_data,
  input  logic              snoop_valid,
  input  logic [LA_W-1:0]   snoop_line
);
  txn_state_e        state;
  logic              wb_wr_en, wb_hit, wb_full, clear_all, snoop_hit, draining;
  logic [CNT_W-1:0]  wb_count;
  logic [PTR_W-1:0]  rd_ptr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  txn_write_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear_all),
    .wr_en   (wb_wr_en),
    .wr_addr (st_addr),
    .wr_data (st_data),
    .lk_addr (ld_addr),
    .lk_hit  (ld_fwd_hit),
    .lk_data (ld_fwd_data),
    .wr_hit  (wb_hit),
    .rd_idx  (rd_ptr),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .count   (wb_count),
    .full    (wb_full)
  );

  txn_read_set #(.LA_W(LA_W), .LINES(L1_LINES)) u_rset (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear_all),
    .set_en   (ld_valid && (state == S_ACTIVE)),
    .set_line (ld_addr[ADDR_W-1:LINE_W]),
    .chk_line (snoop_line),
    .chk_hit  (snoop_hit)
  );

  txn_commit_ctrl #(.DEPTH(WB_DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_valid     (st_valid),
    .wb_hit       (wb_hit),
    .wb_full      (wb_full),
    .wb_count     (wb_count),
    .commit_start (commit_start),
    .cbus_gnt     (cbus_gnt),
    .snoop_valid  (snoop_valid),
    .snoop_hit    (snoop_hit),
    .state        (state),
    .st_ready     (st_ready),
    .wb_wr_en     (wb_wr_en),
    .rd_ptr       (rd_ptr),
    .clear_all    (clear_all),
    .cbus_req     (cbus_req),
    .txn_abort    (txn_abort),
    .commit_done  (commit_done)
  );

  assign draining    = (state == S_COMMIT) || (state == S_OVF_DRAIN);
  assign irrevocable = (state == S_IRREV);

  always_comb begin
    bcast_valid = 1'b0;
    bcast_addr  = '0;
    bcast_data  = '0;
    if (draining) begin
      bcast_valid = 1'b1;
      bcast_addr  = rd_addr;
      bcast_data  = rd_data;
    end else if (irrevocable) begin
      bcast_valid = st_valid;
      bcast_addr  = st_addr;
      bcast_data  = st_data;
    end
  end

  // R5: nothing is broadcast unless this core holds the commit bus
  assert_bcast_needs_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |-> (cbus_req && cbus_gnt));
  // R1: a store taken into the buffer is never visible in the same cycle
  assert_store_hidden_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wb_wr_en |-> !bcast_valid);
endmodule

// File: tb/sim_txn_commit_unit.sv
`timescale 1ns/1ps
module sim_txn_commit_unit;
  logic        clk, rst_n;
  logic        ld_valid, st_valid, commit_start, cbus_gnt, snoop_valid;
  logic [15:0] ld_addr, st_addr;
  logic [31:0] st_data;
  logic [13:0] snoop_line;
  logic        ld_fwd_hit, st_ready, commit_done, txn_abort, irrevocable, cbus_req, bcast_valid;
  logic [31:0] ld_fwd_data, bcast_data;
  logic [15:0] bcast_addr;
  logic [3:0]  arb_req, arb_gnt;
  int checks = 0;
  int errors = 0;

  txn_commit_unit u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_fwd_hit(ld_fwd_hit), .ld_fwd_data(ld_fwd_data), .st_valid(st_valid),
    .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
    .commit_start(commit_start), .commit_done(commit_done), .txn_abort(txn_abort),
    .irrevocable(irrevocable), .cbus_req(cbus_req), .cbus_gnt(cbus_gnt),
    .bcast_valid(bcast_valid), .bcast_addr(bcast_addr), .bcast_data(bcast_data),
    .snoop_valid(snoop_valid), .snoop_line(snoop_line)
  );

  commit_bus_arbiter #(.N(4)) u_arb (.clk(clk), .rst_n(rst_n), .req(arb_req), .gnt(arb_gnt));

  // {request vector, expected grant one cycle later}
  localparam logic [7:0] ARB_VEC [12] = '{
    8'b0001_0001, 8'b0011_0001, 8'b0010_0010, 8'b1110_0010,
    8'b1100_0100, 8'b1101_0100, 8'b1001_1000, 8'b0001_0001,
    8'b0110_0010, 8'b0000_0000, 8'b0101_0100, 8'b0001_0001
  };

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; ld_valid = 0; ld_addr = '0; st_valid = 0; st_addr = '0; st_data = '0;
    commit_start = 0; cbus_gnt = 0; snoop_valid = 0; snoop_line = '0; arb_req = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // reset state
    chk("R5 reset req", 32'(cbus_req), 0);
    chk("R8 reset ready", 32'(st_ready), 1);
    chk("R1 reset bcast", 32'(bcast_valid), 0);
    chk("R3 reset abort", 32'(txn_abort), 0);
    chk("R6 reset done", 32'(commit_done), 0);
    chk("R9 reset irrev", 32'(irrevocable), 0);
    chk("R10 reset gnt", 32'(arb_gnt), 0);

    // arbiter table walk, R10 hold and R11 round-robin order
    for (int i = 0; i < 12; i++) begin
      arb_req = ARB_VEC[i][7:4];
      tick();
      chk("R11 arbiter grant", 32'(arb_gnt), 32'(ARB_VEC[i][3:0]));
    end
    arb_req = '0;

    // R1/R2: buffered stores with a merge
    st_valid = 1; st_addr = 16'h0010; st_data = 32'hA1; tick();
    st_addr = 16'h0020; st_data = 32'hA2;
    chk("R1 no early bcast", 32'(bcast_valid), 0);
    tick();
    st_addr = 16'h0010; st_data = 32'hA3; tick();
    st_valid = 0; ld_addr = 16'h0010; #1;
    chk("R1 fwd hit", 32'(ld_fwd_hit), 1);
    chk("R1 fwd newest", ld_fwd_data, 32'hA3);
    ld_addr = 16'h0030; #1;
    chk("R1 fwd miss", 32'(ld_fwd_hit), 0);

    // R5: commit through the bus
    commit_start = 1; tick(); commit_start = 0;
    chk("R5 req raised", 32'(cbus_req), 1);
    chk("R5 no bcast before grant", 32'(bcast_valid), 0);
    tick();
    chk("R5 still waiting", 32'(bcast_valid), 0);
    cbus_gnt = 1; tick();
    chk("R2 first word valid", 32'(bcast_valid), 1);
    chk("R2 first addr", 32'(bcast_addr), 32'h0010);
    chk("R2 merged data", bcast_data, 32'hA3);
    tick();
    chk("R2 second addr", 32'(bcast_addr), 32'h0020);
    chk("R2 second data", bcast_data, 32'hA2);
    tick();
    chk("R5 done pulse", 32'(commit_done), 1);
    chk("R5 req dropped", 32'(cbus_req), 0);
    chk("R2 two words only", 32'(bcast_valid), 0);
    cbus_gnt = 0; ld_addr = 16'h0010; #1;
    chk("R7 buffer cleared on commit", 32'(ld_fwd_hit), 0);
    tick();
    chk("R5 done one cycle", 32'(commit_done), 0);

    // R3/R7: snoop abort
    st_valid = 1; st_addr = 16'h0100; st_data = 32'hD0; tick();
    st_valid = 0; ld_valid = 1; ld_addr = 16'h0044; tick();
    ld_valid = 0; snoop_valid = 1; snoop_line = 14'h0011; tick();
    snoop_valid = 0;
    chk("R3 abort pulse", 32'(txn_abort), 1);
    ld_addr = 16'h0100; #1;
    chk("R7 buffer cleared on abort", 32'(ld_fwd_hit), 0);
    tick();
    chk("R3 abort one cycle", 32'(txn_abort), 0);
    snoop_valid = 1; snoop_line = 14'h0011; tick(); snoop_valid = 0;
    chk("R7 read bits cleared", 32'(txn_abort), 0);

    // R4: unread line
    ld_valid = 1; ld_addr = 16'h0080; tick();
    ld_valid = 0; snoop_valid = 1; snoop_line = 14'h0024; tick(); snoop_valid = 0;
    chk("R4 no abort on clear bit", 32'(txn_abort), 0);
    snoop_valid = 1; snoop_line = 14'h0020; tick(); snoop_valid = 0;
    chk("R3 abort on read line", 32'(txn_abort), 1);
    tick();

    // R3: abort while waiting for the bus
    st_valid = 1; st_addr = 16'h0040; st_data = 32'hE0; tick();
    st_valid = 0; ld_valid = 1; ld_addr = 16'h0050; tick();
    ld_valid = 0; commit_start = 1; tick(); commit_start = 0;
    chk("R5 req before abort", 32'(cbus_req), 1);
    snoop_valid = 1; snoop_line = 14'h0014; tick(); snoop_valid = 0;
    chk("R3 abort while requesting", 32'(txn_abort), 1);
    chk("R3 request dropped", 32'(cbus_req), 0);
    tick();

    // R6: read-only commit
    ld_valid = 1; ld_addr = 16'h0060; tick();
    ld_valid = 0; commit_start = 1; tick(); commit_start = 0;
    chk("R6 immediate done", 32'(commit_done), 1);
    chk("R6 no request", 32'(cbus_req), 0);
    snoop_valid = 1; snoop_line = 14'h0018; tick(); snoop_valid = 0;
    chk("R7 bits cleared on commit", 32'(txn_abort), 0);

    // R8/R9: overflow into irrevocable mode
    ld_valid = 1; ld_addr = 16'h0300; tick(); ld_valid = 0;
    for (int i = 0; i < 16; i++) begin
      st_valid = 1; st_addr = 16'h0200 + 16'(i); st_data = 32'h1000 + 32'(i); tick();
    end
    st_addr = 16'h0205; st_data = 32'hBEEF; #1;
    chk("R2 merge while full", 32'(st_ready), 1);
    tick();
    st_addr = 16'h0210; st_data = 32'h2222; #1;
    chk("R8 stall on overflow", 32'(st_ready), 0);
    tick();
    chk("R8 bus requested", 32'(cbus_req), 1);
    chk("R8 still stalled", 32'(st_ready), 0);
    chk("R1 nothing out before grant", 32'(bcast_valid), 0);
    cbus_gnt = 1; tick();
    for (int i = 0; i < 16; i++) begin
      chk("R8 drain valid", 32'(bcast_valid), 1);
      chk("R8 drain addr", 32'(bcast_addr), 32'h0200 + 32'(i));
      chk("R8 drain data", bcast_data, (i == 5) ? 32'hBEEF : 32'h1000 + 32'(i));
      tick();
    end
    chk("R8 irrevocable", 32'(irrevocable), 1);
    chk("R8 ready again", 32'(st_ready), 1);
    chk("R8 write-through valid", 32'(bcast_valid), 1);
    chk("R8 write-through addr", 32'(bcast_addr), 32'h0210);
    chk("R8 write-through data", bcast_data, 32'h2222);
    st_valid = 0; snoop_valid = 1; snoop_line = 14'h00C0; #1;
    chk("R8 idle no bcast", 32'(bcast_valid), 0);
    tick(); snoop_valid = 0;
    chk("R9 snoop ignored", 32'(txn_abort), 0);
    chk("R9 bus kept", 32'(cbus_req), 1);
    st_valid = 1; st_addr = 16'h0400; st_data = 32'h3333; #1;
    chk("R8 second write-through", 32'(bcast_addr), 32'h0400);
    tick(); st_valid = 0;
    commit_start = 1; tick(); commit_start = 0;
    chk("R9 done pulse", 32'(commit_done), 1);
    chk("R9 bus released", 32'(cbus_req), 0);
    chk("R9 left irrevocable", 32'(irrevocable), 0);
    cbus_gnt = 0;
    tick();
    summary();
  end
endmodule